// File: doc/BRIEF.md
# DMA Channel Register Bank with Alias Windows

This block is the register bank for a set of DMA channels. For each channel it stores a read address, a write address, a transfer count and a control word. It also produces one-cycle start and abort strobes for the data movement engine that sits beside it. Software reaches the bank through a single word-wide port that carries a write enable, a byte address, write data and combinational read data.

Each channel owns a 64-byte window. Inside that window the same four registers appear four times, once in each of four alias views, and each view lists them in its own order. Only the last word of a view starts the channel. Software can therefore choose which register to write last and use that final store to launch the transfer. A global region holds a multi-channel trigger word and an abort word. The abort word keeps each requested bit set until the engine reports that the channel is idle.

Top module: `dmareg_bank`

## Requirements
- R1: After reset every stored register reads zero through every offset, and `start_o` and `abort_o` are low.
- R2: Channel n decodes at byte address n*0x40 when `bus_addr` bits 11:10 are zero. A channel index of NCH or more is ignored and reads zero.
- R3: Word w (0..15) of a channel window is slot `w%4` of view `w/4`. View 0 holds read address, write address, count, control. View 1 holds control, read address, write address, count. View 2 holds control, count, read address, write address. View 3 holds control, write address, count, read address. Every offset reads back the register it names.
- R4: A write to slot 3 of any view starts the channel when control bit 0 (enable) is set: `start_o[n]` is high for exactly the cycle after the write edge. A write to slots 0 to 2 never starts the channel. For a control write in slot 3, the enable is taken from the written value.
- R5: A trigger for a channel whose enable bit is clear does not assert `start_o`.
- R6: Writing mask m to global offset 0x400 starts, in the next cycle, every channel n whose bit m[n] is 1 and whose enable is set. Several channels can start together. The offset reads zero.
- R7: Control bit 29 (read error) and bit 30 (write error) are set by `rd_err_i[n]` and `wr_err_i[n]` and stay set. A control write with a 1 in that bit position clears the bit. A 0 leaves it set.
- R8: Control bit 26 reads `busy_i[n]` and cannot be written. Bits 27, 28 and 31 read zero. Bits 25:0 are stored as written.
- R9: Writing mask m to global offset 0x404 pulses `abort_o` with m in the next cycle and sets pending bits. These bits read back at 0x404 and each clears at the first clock edge after it was set where `busy_i[n]` is low.
- R10: Writes with `bus_addr[1:0]` not zero, writes to global offsets other than 0x400 and 0x404, and writes above the global region change nothing and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | AW | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| busy_i | input | NCH | Engine reports the channel is moving data |
| rd_err_i | input | NCH | Sets the sticky read-error bit |
| wr_err_i | input | NCH | Sets the sticky write-error bit |
| start_o | output | NCH | One-cycle channel start strobe |
| abort_o | output | NCH | One-cycle channel abort strobe |
| raddr_o | output | NCH*32 | Read address of each channel |
| waddr_o | output | NCH*32 | Write address of each channel |
| count_o | output | NCH*32 | Transfer count of each channel |
| ctrl_o | output | NCH*32 | Control word of each channel, including status bits |

## Verification
The assertions assume at most one bus write per cycle. They also assume that the status inputs are clean levels sampled at the clock edge, so that a start can only follow a write and an error can only appear after its input was raised. The random stimulus keeps to these assumptions. It issues one write per cycle at most and holds `busy_i` and the error inputs low. Those inputs are changed only in the directed error, busy and abort passes, and each of those passes changes one input and then checks the effect.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

   typedef enum logic [1:0] {
      FLD_RADDR = 2'd0,
      FLD_WADDR = 2'd1,
      FLD_COUNT = 2'd2,
      FLD_CTRL  = 2'd3
   } fld_e;

   localparam int EN_BIT    = 0;
   localparam int BUSY_BIT  = 26;
   localparam int RDERR_BIT = 29;
   localparam int WRERR_BIT = 30;
   localparam int STORE_W   = 26;

   localparam int WIN_SHIFT  = 6;
   localparam int GLOB_SHIFT = 10;
   localparam int CIDX_W     = GLOB_SHIFT - WIN_SHIFT;
   localparam int MAX_CH     = 1 << CIDX_W;

   // view order: the slot that triggers is always the last one
   function automatic fld_e view_field(input logic [1:0] view, input logic [1:0] slot);
      fld_e f;
      unique case (view)
         2'd0: f = fld_e'(slot);
         2'd1: f = (slot == 2'd0) ? FLD_CTRL : fld_e'(slot - 2'd1);
         2'd2: begin
            unique case (slot)
               2'd0: f = FLD_CTRL;
               2'd1: f = FLD_COUNT;
               2'd2: f = FLD_RADDR;
               default: f = FLD_WADDR;
            endcase
         end
         default: begin
            unique case (slot)
               2'd0: f = FLD_CTRL;
               2'd1: f = FLD_WADDR;
               2'd2: f = FLD_COUNT;
               default: f = FLD_RADDR;
            endcase
         end
      endcase
      return f;
   endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
   import dmareg_pkg::*;
#(
   parameter int AW  = 12,
   parameter int NCH = 4
) (
   input  logic [AW-1:0]     addr_i,
   output logic              ch_hit_o,
   output logic [CIDX_W-1:0] ch_idx_o,
   output fld_e              fld_o,
   output logic              trig_o,
   output logic              gtrig_hit_o,
   output logic              gabort_hit_o
);
   localparam int RW = AW - GLOB_SHIFT;

   if (AW < GLOB_SHIFT + 1) begin : g_aw_bad
      $error("dmareg_decode: AW must be at least %0d", GLOB_SHIFT + 1);
   end
   if (NCH < 1 || NCH > MAX_CH) begin : g_nch_bad
      $error("dmareg_decode: NCH out of range");
   end

   logic [RW-1:0]         region;
   logic                  aligned;
   logic                  in_chan;
   logic                  in_glob;
   logic [3:0]            word;
   logic [GLOB_SHIFT-3:0] gword;

   assign region  = addr_i[AW-1:GLOB_SHIFT];
   assign aligned = (addr_i[1:0] == 2'b00);
   assign in_chan = aligned && (region == '0);
   assign in_glob = aligned && (region == RW'(1));
   assign word    = addr_i[WIN_SHIFT-1:2];
   assign gword   = addr_i[GLOB_SHIFT-1:2];

   assign ch_idx_o     = addr_i[GLOB_SHIFT-1:WIN_SHIFT];
   assign ch_hit_o     = in_chan && (int'(ch_idx_o) < NCH);
   assign fld_o        = view_field(word[3:2], word[1:0]);
   assign trig_o       = (word[1:0] == 2'b11);
   assign gtrig_hit_o  = in_glob && (gword == '0);
   assign gabort_hit_o = in_glob && (gword == (GLOB_SHIFT-2)'(1));

endmodule

// File: rtl/dmareg_chan.sv
module dmareg_chan
   import dmareg_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_i,
   input  fld_e          fld_i,
   input  logic          trig_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          mtrig_i,
   input  logic          busy_i,
   input  logic          rderr_i,
   input  logic          wrerr_i,
   output logic [DW-1:0] raddr_o,
   output logic [DW-1:0] waddr_o,
   output logic [DW-1:0] count_o,
   output logic [DW-1:0] ctrl_o,
   output logic [DW-1:0] rdata_o,
   output logic          start_o
);
   if (DW != 32) begin : g_dw_bad
      $error("dmareg_chan: control layout needs DW of 32");
   end

   logic [DW-1:0]      raddr_q, waddr_q, count_q;
   logic [STORE_W-1:0] cfg_q;
   logic               rderr_q, wrerr_q;
   logic               start_q;
   logic               wr_ctrl;
   logic               en_eff;
   logic               go;

   assign wr_ctrl = wr_i && (fld_i == FLD_CTRL);
   assign en_eff  = wr_ctrl ? wdata_i[EN_BIT] : cfg_q[EN_BIT];
   assign go      = (wr_i && trig_i && en_eff) || (mtrig_i && cfg_q[EN_BIT]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raddr_q <= '0;
         waddr_q <= '0;
         count_q <= '0;
         cfg_q   <= '0;
      end else if (wr_i) begin
         unique case (fld_i)
            FLD_RADDR: raddr_q <= wdata_i;
            FLD_WADDR: waddr_q <= wdata_i;
            FLD_COUNT: count_q <= wdata_i;
            default:   cfg_q   <= wdata_i[STORE_W-1:0];
         endcase
      end
   end

   // sticky error bits: a set from the engine wins over a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rderr_q <= 1'b0;
         wrerr_q <= 1'b0;
      end else begin
         rderr_q <= rderr_i || (rderr_q && !(wr_ctrl && wdata_i[RDERR_BIT]));
         wrerr_q <= wrerr_i || (wrerr_q && !(wr_ctrl && wdata_i[WRERR_BIT]));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_q <= 1'b0;
      else        start_q <= go;
   end

   assign raddr_o = raddr_q;
   assign waddr_o = waddr_q;
   assign count_o = count_q;
   assign ctrl_o  = {1'b0, wrerr_q, rderr_q, 2'b00, busy_i, cfg_q};
   assign start_o = start_q;

   always_comb begin
      unique case (fld_i)
         FLD_RADDR: rdata_o = raddr_q;
         FLD_WADDR: rdata_o = waddr_q;
         FLD_COUNT: rdata_o = count_q;
         default:   rdata_o = ctrl_o;
      endcase
   end

   // R5
   start_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> cfg_q[EN_BIT]);
   // R4
   nontrig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !trig_i && !mtrig_i) |=> !start_o);
   // R7
   rderr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rderr_i |=> ctrl_o[RDERR_BIT]);
   // R7
   wrerr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrerr_q && !wr_ctrl) |=> wrerr_q);

endmodule

// File: rtl/dmareg_glob.sv
module dmareg_glob #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           trig_wr_i,
   input  logic           abort_wr_i,
   input  logic [NCH-1:0] mask_i,
   input  logic [NCH-1:0] busy_i,
   output logic [NCH-1:0] mtrig_o,
   output logic [NCH-1:0] abort_o,
   output logic [NCH-1:0] pend_o
);
   logic [NCH-1:0] abort_q;
   logic [NCH-1:0] pend_q;

   assign mtrig_o = trig_wr_i ? mask_i : '0;

   for (genvar n = 0; n < NCH; n++) begin : g_ab
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            abort_q[n] <= 1'b0;
            pend_q[n]  <= 1'b0;
         end else begin
            abort_q[n] <= abort_wr_i && mask_i[n];
            pend_q[n]  <= (abort_wr_i && mask_i[n]) || (pend_q[n] && busy_i[n]);
         end
      end

      // R9
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (pend_q[n] && busy_i[n]) |=> pend_q[n]);
      // R9
      abort_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         abort_q[n] |-> pend_q[n]);
   end

   assign abort_o = abort_q;
   assign pend_o  = pend_q;

endmodule

// File: rtl/dmareg_bank.sv
module dmareg_bank
   import dmareg_pkg::*;
#(
   parameter int AW  = 12,
   parameter int NCH = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_we,
   input  logic [AW-1:0]   bus_addr,
   input  logic [31:0]     bus_wdata,
   output logic [31:0]     bus_rdata,
   input  logic [NCH-1:0]  busy_i,
   input  logic [NCH-1:0]  rd_err_i,
   input  logic [NCH-1:0]  wr_err_i,
   output logic [NCH-1:0]  start_o,
   output logic [NCH-1:0]  abort_o,
   output logic [NCH*32-1:0] raddr_o,
   output logic [NCH*32-1:0] waddr_o,
   output logic [NCH*32-1:0] count_o,
   output logic [NCH*32-1:0] ctrl_o
);
   localparam int DW = 32;

   logic              ch_hit;
   logic [CIDX_W-1:0] ch_idx;
   fld_e              fld;
   logic              trig;
   logic              gtrig_hit, gabort_hit;
   logic [NCH-1:0]    mtrig;
   logic [NCH-1:0]    pend;
   logic [DW-1:0]     ch_rd [NCH];

   dmareg_decode #(.AW(AW), .NCH(NCH)) u_dec (
      .addr_i       (bus_addr),
      .ch_hit_o     (ch_hit),
      .ch_idx_o     (ch_idx),
      .fld_o        (fld),
      .trig_o       (trig),
      .gtrig_hit_o  (gtrig_hit),
      .gabort_hit_o (gabort_hit)
   );

   dmareg_glob #(.NCH(NCH)) u_glob (
      .clk        (clk),
      .rst_n      (rst_n),
      .trig_wr_i  (bus_we && gtrig_hit),
      .abort_wr_i (bus_we && gabort_hit),
      .mask_i     (bus_wdata[NCH-1:0]),
      .busy_i     (busy_i),
      .mtrig_o    (mtrig),
      .abort_o    (abort_o),
      .pend_o     (pend)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic wr_n;
      assign wr_n = bus_we && ch_hit && (ch_idx == CIDX_W'(n));

      dmareg_chan #(.DW(DW)) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_i    (wr_n),
         .fld_i   (fld),
         .trig_i  (trig),
         .wdata_i (bus_wdata),
         .mtrig_i (mtrig[n]),
         .busy_i  (busy_i[n]),
         .rderr_i (rd_err_i[n]),
         .wrerr_i (wr_err_i[n]),
         .raddr_o (raddr_o[n*DW +: DW]),
         .waddr_o (waddr_o[n*DW +: DW]),
         .count_o (count_o[n*DW +: DW]),
         .ctrl_o  (ctrl_o[n*DW +: DW]),
         .rdata_o (ch_rd[n]),
         .start_o (start_o[n])
      );

      // R4
      start_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
         start_o[n] |-> $past(bus_we));
   end

   always_comb begin
      bus_rdata = '0;
      for (int n = 0; n < NCH; n++) begin
         if (ch_hit && ch_idx == CIDX_W'(n)) bus_rdata = ch_rd[n];
      end
      if (gabort_hit) bus_rdata = DW'(pend);
   end

   // R10
   idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_we) |-> (abort_o == '0 && start_o == '0));

endmodule

// File: tb/sim_dmareg_bank.sv
module sim_dmareg_bank;
   localparam int CLK_NS = 10;
   localparam int AW     = 12;
   localparam int NCH    = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              bus_we = 1'b0;
   logic [AW-1:0]     bus_addr = '0;
   logic [31:0]       bus_wdata = '0;
   logic [31:0]       bus_rdata;
   logic [NCH-1:0]    busy_i = '0;
   logic [NCH-1:0]    rd_err_i = '0;
   logic [NCH-1:0]    wr_err_i = '0;
   logic [NCH-1:0]    start_o, abort_o;
   logic [NCH*32-1:0] raddr_o, waddr_o, count_o, ctrl_o;

   int total = 0;
   int bad   = 0;

   logic [31:0] m_reg [NCH][4];
   logic        m_rde [NCH];
   logic        m_wre [NCH];

   dmareg_bank #(.AW(AW), .NCH(NCH)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy_i(busy_i),
      .rd_err_i(rd_err_i), .wr_err_i(wr_err_i), .start_o(start_o),
      .abort_o(abort_o), .raddr_o(raddr_o), .waddr_o(waddr_o),
      .count_o(count_o), .ctrl_o(ctrl_o)
   );

   always #(CLK_NS/2) clk = ~clk;

   initial begin
      #(CLK_NS * 150000);
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // field index: 0 read addr, 1 write addr, 2 count, 3 control
   function automatic int fld_at(input int word);
      int v = word / 4, s = word % 4;
      case (v)
         0: return s;
         1: return (s == 0) ? 3 : s - 1;
         2: return (s == 0) ? 3 : (s == 1) ? 2 : (s == 2) ? 0 : 1;
         default: return (s == 0) ? 3 : (s == 1) ? 1 : (s == 2) ? 2 : 0;
      endcase
   endfunction

   function automatic logic [31:0] m_view(input int ch, input int f);
      if (f != 3) return m_reg[ch][f];
      return (m_reg[ch][3] & 32'h03FF_FFFF) | (32'(busy_i[ch]) << 26)
           | (32'(m_rde[ch]) << 29) | (32'(m_wre[ch]) << 30);
   endfunction

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk); #1;
      bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
      bus_addr = a; #1;
      chk(tag, bus_rdata, exp);
   endtask

   function automatic logic [NCH-1:0] en_mask();
      logic [NCH-1:0] m;
      for (int n = 0; n < NCH; n++) m[n] = m_reg[n][3][0];
      return m;
   endfunction

   task automatic ch_wr(input int ch, input int word, input logic [31:0] d);
      int f = fld_at(word);
      logic [NCH-1:0] exp;
      if (f == 3) begin
         m_reg[ch][3] = d & 32'h03FF_FFFF;
         if (d[29]) m_rde[ch] = 1'b0;
         if (d[30]) m_wre[ch] = 1'b0;
      end else m_reg[ch][f] = d;
      exp = '0;
      if ((word % 4) == 3 && m_reg[ch][3][0]) exp[ch] = 1'b1;
      bus_wr(AW'(ch * 64 + word * 4), d);
      chk("R4 start", 32'(start_o), 32'(exp));
   endtask

   initial begin
      process::self().srandom(32'd7341);
      for (int n = 0; n < NCH; n++) begin
         for (int f = 0; f < 4; f++) m_reg[n][f] = '0;
         m_rde[n] = 1'b0; m_wre[n] = 1'b0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset state
      chk("R1 start", 32'(start_o), 0);
      chk("R1 abort", 32'(abort_o), 0);
      for (int n = 0; n < NCH; n++)
         for (int w = 0; w < 16; w++) rd_chk("R1 reg", AW'(n*64 + w*4), 0);

      // R3 one register through several views
      ch_wr(1, 5, 32'hA5A5_0001);
      rd_chk("R3 view0 raddr", AW'(64 + 0), 32'hA5A5_0001);
      rd_chk("R3 view2 raddr", AW'(64 + 40), 32'hA5A5_0001);
      rd_chk("R3 view3 raddr", AW'(64 + 60), 32'hA5A5_0001);
      ch_wr(1, 13, 32'h0000_1234);
      rd_chk("R3 view1 waddr", AW'(64 + 24), 32'h0000_1234);

      // R5 trigger with enable clear, R4 trigger with enable set
      ch_wr(2, 3, 32'h0000_00F0);
      ch_wr(2, 7, 32'd16);
      ch_wr(2, 8, 32'h0000_0001);
      ch_wr(2, 11, 32'h2000_0000);
      ch_wr(2, 15, 32'h1000_0000);
      ch_wr(2, 9, 32'd4);
      chk("R4 quiet after", 32'(start_o), 0);

      // R6 several channels at once
      ch_wr(0, 4, 32'h1);
      bus_wr(AW'('h400), 32'hF);
      chk("R6 multi", 32'(start_o), 32'(en_mask()));
      rd_chk("R6 reads zero", AW'('h400), 0);

      // R7 sticky errors
      rd_err_i[1] = 1'b1; wr_err_i[1] = 1'b1;
      @(posedge clk); #1;
      rd_err_i = '0; wr_err_i = '0;
      m_rde[1] = 1'b1; m_wre[1] = 1'b1;
      rd_chk("R7 set", AW'(64 + 16), m_view(1, 3));
      ch_wr(1, 4, 32'h0);
      rd_chk("R7 zero keeps", AW'(64 + 32), m_view(1, 3));
      ch_wr(1, 8, 32'h2000_0000);
      rd_chk("R7 clear read err", AW'(64 + 48), 32'h4000_0000);

      // R8 busy bit and unwritable high bits
      ch_wr(3, 4, 32'hFFFF_FFFE);
      rd_chk("R8 mask", AW'(192 + 16), 32'h03FF_FFFE);
      busy_i[3] = 1'b1;
      rd_chk("R8 busy", AW'(192 + 16), 32'h07FF_FFFE);

      // R9 abort pending follows busy
      bus_wr(AW'('h404), 32'h9);
      chk("R9 pulse", 32'(abort_o), 32'h9);
      rd_chk("R9 pend both", AW'('h404), 32'h9);
      @(posedge clk); #1;
      chk("R9 pulse ends", 32'(abort_o), 0);
      rd_chk("R9 idle clears", AW'('h404), 32'h8);
      repeat (3) @(posedge clk); #1;
      rd_chk("R9 busy holds", AW'('h404), 32'h8);
      busy_i[3] = 1'b0;
      @(posedge clk); #1;
      rd_chk("R9 released", AW'('h404), 0);

      // R10 and R2 ignored writes
      bus_wr(AW'('h408), 32'hFFFF_FFFF);
      chk("R10 start", 32'(start_o), 0);
      rd_chk("R10 undef", AW'('h408), 0);
      bus_wr(AW'(NCH*64 + 12), 32'hFFFF_FFFF);
      chk("R2 no start", 32'(start_o), 0);
      rd_chk("R2 beyond", AW'(NCH*64), 0);
      bus_wr(AW'(64 + 2), 32'hDEAD_BEEF);
      bus_wr(AW'('h805), 32'hDEAD_BEEF);
      bus_wr(AW'('h800), 32'hDEAD_BEEF);
      rd_chk("R10 high", AW'('h800), 0);
      for (int n = 0; n < NCH; n++)
         for (int f = 0; f < 4; f++) rd_chk("R10 untouched", AW'(n*64 + f*4 + 0), m_view(n, fld_at(f)));

      // random mix
      for (int i = 0; i < 600; i++) begin
         int ch = $urandom % NCH;
         int w  = $urandom % 16;
         if (($urandom % 8) == 0) begin
            logic [NCH-1:0] m = NCH'($urandom);
            bus_wr(AW'('h400), 32'(m));
            chk("R6 rand", 32'(start_o), 32'(m & en_mask()));
         end else begin
            ch_wr(ch, w, $urandom);
         end
         ch = $urandom % NCH;
         w  = $urandom % 16;
         rd_chk("R3 rand", AW'(ch*64 + w*4), m_view(ch, fld_at(w)));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule